// File: doc/BRIEF.md
# Four-Register Three-Bus Datapath

This block is a small execution datapath. It holds four 4-bit registers, feeds two of them onto a pair of read buses that supply a classic 4-bit ALU slice, and writes one register from a write bus. The write bus carries either an external input nibble or the ALU result. A single 13-bit control word, applied fresh every cycle, selects the write-bus source, the ALU mode, the ALU carry-in, the ALU function and the three register addresses. A separate write strobe commits the result. Microprogram storage and sequencing sit outside the block.

Both register reads and the ALU are combinational, so the carry-out responds in the same cycle as the control word. The destination register changes only on the rising clock edge while the write strobe is high. All register contents are visible on one packed observation port.

Top module: `tribus_datapath`

## Requirements
- R1: Reset is active-low and synchronous. A rising clock edge with rst_n low clears all four registers to zero.
- R2: Control word layout, from bit 12 down: bit 12 selects the write-bus source (0 = ext_in, 1 = ALU result), bit 11 is the ALU mode (1 = logic), bit 10 is the active-high carry-in, bits 9:6 are the function select S3..S0, bits 5:4 are the A-operand register address, bits 3:2 are the B-operand register address, and bits 1:0 are the destination register address.
- R3: With bit 12 = 0 and wr_en high, the destination register takes ext_in at the rising edge. The mode, carry, function and operand fields have no effect on that write.
- R4: Only the addressed destination register can change, and only when wr_en is high. With wr_en low, every register holds its value.
- R5: Mode 0, carry 0 and S = 1001 give A plus B, modulo 16. Running R3 = R0 + R1 and then R3 = R3 + R2 from R0=2, R1=3, R2=4 leaves R3 = 9.
- R6: Mode 0, carry 1 and S = 0110 give A minus B, modulo 16. For example, 2 minus 3 gives 1111.
- R7: In mode 1 the carry-in is ignored and the function select picks one of 16 bitwise functions. Among them: 0000 = NOT A, 0001 = NOR, 0010 = (NOT A) AND B, 0011 = 0, 0100 = NAND, 0101 = NOT B, 0110 = XOR, 0111 = A AND NOT B, 1000 = (NOT A) OR B, 1001 = XNOR, 1010 = B, 1011 = AND, 1100 = 1111, 1101 = A OR NOT B, 1110 = OR, 1111 = A.
- R8: In mode 0 the result is P + Q + carry-in, modulo 16, where P = A | (B & S0) | (~B & S1) and Q = (A & B & S3) | (A & ~B & S2), evaluated bitwise.
- R9: alu_cout is bit 4 of the 5-bit sum P + Q + carry-in in mode 0, and 0 in mode 1. It is combinational and is never stored.
- R10: Operand reads are combinational. The A and B fields may name the same register, and the destination may also be an operand. The result uses the register values from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Commit strobe for the destination register |
| ctrl | input | 13 | Control word (layout in R2) |
| ext_in | input | 4 | External data for the write bus |
| regs_q | output | 16 | Register contents, R0 in bits 3:0 up to R3 in bits 15:12 |
| alu_cout | output | 1 | ALU carry-out for the current control word |

## Verification
The carry-out is due in the same cycle as the control word, with no register in its path. A register result is due one rising edge after the control word and strobe that produce it. The bench drives each new control word just after a falling edge and samples alu_cout 1 ns later. It samples all four registers at the next falling edge, which falls after exactly one rising edge. A behavioural model, updated at that same point, supplies the expected values. The checks therefore never straddle two writes.

// File: rtl/tribus_pkg.sv
// Package: shared widths, control-word layout and named function selects
// for the four-register three-bus datapath.
// Assumes: the register count is a power of two, so the address width is exact.
package tribus_pkg;

    localparam int DP_DATA_W   = 4;
    localparam int DP_NUM_REGS = 4;
    localparam int DP_ADDR_W   = $clog2(DP_NUM_REGS);
    localparam int DP_FSEL_W   = 4;

    // Control word, most significant field first (layout is behaviour).
    typedef struct packed {
        logic                 src_alu;     // 1: ALU result on write bus
        logic                 logic_mode;  // 1: bitwise functions
        logic                 carry_in;    // active-high carry into bit 0
        logic [DP_FSEL_W-1:0] fsel;        // function select S3..S0
        logic [DP_ADDR_W-1:0] a_addr;      // register on the A bus
        logic [DP_ADDR_W-1:0] b_addr;      // register on the B bus
        logic [DP_ADDR_W-1:0] d_addr;      // destination register
    } dp_ctrl_t;

    localparam int DP_CTRL_W = $bits(dp_ctrl_t);

    // Frequently used function selects.
    localparam logic [DP_FSEL_W-1:0] FS_ADD  = 4'b1001;
    localparam logic [DP_FSEL_W-1:0] FS_SUB  = 4'b0110;
    localparam logic [DP_FSEL_W-1:0] FS_AND  = 4'b1011;
    localparam logic [DP_FSEL_W-1:0] FS_OR   = 4'b1110;
    localparam logic [DP_FSEL_W-1:0] FS_XOR  = 4'b0110;
    localparam logic [DP_FSEL_W-1:0] FS_NOTA = 4'b0000;

endpackage

// File: rtl/tribus_onehot_dec.sv
// Module: binary-to-one-hot decoder for register enables.
// Assumes: NUM_OUT <= 2**ADDR_W. The output is all-zero when en is low.
module tribus_onehot_dec #(
    parameter int ADDR_W  = 2,
    parameter int NUM_OUT = 4
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_OUT-1:0] sel
);

    // One comparator per output line.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
        assign sel[i] = en && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/tribus_regfile.sv
// Module: register bank with one-hot write enables and two one-hot-enabled
// read buses (AND-OR, standing in for bus drivers).
// Assumes: at most one write enable is set. Each read enable is one-hot.
module tribus_regfile #(
    parameter int DATA_W   = 4,
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_REGS-1:0]        a_sel,
    input  logic [NUM_REGS-1:0]        b_sel,
    output logic [DATA_W-1:0]          a_bus,
    output logic [DATA_W-1:0]          b_bus,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] store [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold, clear on reset, or load from the write bus when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[i] <= '0;
            else if (wr_sel[i])
                store[i] <= wr_data;
        end
        assign regs_flat[i*DATA_W +: DATA_W] = store[i];
    end

    // Merge the enabled register onto each read bus.
    always_comb begin
        a_bus = '0;
        b_bus = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            a_bus = a_bus | ({DATA_W{a_sel[i]}} & store[i]);
            b_bus = b_bus | ({DATA_W{b_sel[i]}} & store[i]);
        end
    end

endmodule

// File: rtl/tribus_alu.sv
// Module: classic 4-bit ALU slice, widened by parameter. Per bit it forms
// P = A | B&S0 | ~B&S1 and Q = A&B&S3 | A&~B&S2. Arithmetic mode returns
// P + Q + cin. Logic mode returns ~(P ^ Q) with the carry ignored.
// Assumes: the carry-in is active high. cout is forced low in logic mode.
module tribus_alu #(
    parameter int DATA_W = 4,
    parameter int FSEL_W = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              logic_mode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] y,
    output logic              cout
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] p_term;
    logic [DATA_W-1:0] q_term;
    logic [SUM_W-1:0]  sum;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign p_term[i] = a[i] | (b[i] & fsel[0]) | (~b[i] & fsel[1]);
        assign q_term[i] = (a[i] & b[i] & fsel[3]) | (a[i] & ~b[i] & fsel[2]);
    end

    // Ripple sum of the two terms and the carry.
    assign sum = SUM_W'(p_term) + SUM_W'(q_term) + SUM_W'(carry_in);

    // Pick the arithmetic or bitwise result.
    always_comb begin
        if (logic_mode) begin
            y    = ~(p_term ^ q_term);
            cout = 1'b0;
        end else begin
            y    = sum[DATA_W-1:0];
            cout = sum[DATA_W];
        end
    end

endmodule

// File: rtl/tribus_datapath.sv
// Module: top of the four-register three-bus datapath. It splits the control
// word, decodes the A, B and destination addresses, runs the ALU on the two
// read buses and writes the chosen write-bus value to one register.
// Assumes: the control word is stable around the rising edge. The reset is
// synchronous and active low.
module tribus_datapath
    import tribus_pkg::*;
#(
    parameter int DATA_W   = DP_DATA_W,
    parameter int NUM_REGS = DP_NUM_REGS,
    parameter int CTRL_W   = DP_CTRL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CTRL_W-1:0]          ctrl,
    input  logic [DATA_W-1:0]          ext_in,
    output logic [NUM_REGS*DATA_W-1:0] regs_q,
    output logic                       alu_cout
);

    dp_ctrl_t            cw;
    logic [NUM_REGS-1:0] a_sel;
    logic [NUM_REGS-1:0] b_sel;
    logic [NUM_REGS-1:0] d_sel;
    logic [DATA_W-1:0]   a_bus;
    logic [DATA_W-1:0]   b_bus;
    logic [DATA_W-1:0]   alu_y;
    logic [DATA_W-1:0]   c_bus;

    assign cw = dp_ctrl_t'(ctrl);

    tribus_onehot_dec #(.ADDR_W(DP_ADDR_W), .NUM_OUT(NUM_REGS)) u_dec_a (
        .en(1'b1), .addr(cw.a_addr), .sel(a_sel)
    );
    tribus_onehot_dec #(.ADDR_W(DP_ADDR_W), .NUM_OUT(NUM_REGS)) u_dec_b (
        .en(1'b1), .addr(cw.b_addr), .sel(b_sel)
    );
    tribus_onehot_dec #(.ADDR_W(DP_ADDR_W), .NUM_OUT(NUM_REGS)) u_dec_d (
        .en(wr_en), .addr(cw.d_addr), .sel(d_sel)
    );

    tribus_alu #(.DATA_W(DATA_W), .FSEL_W(DP_FSEL_W)) u_alu (
        .a(a_bus), .b(b_bus), .fsel(cw.fsel),
        .logic_mode(cw.logic_mode), .carry_in(cw.carry_in),
        .y(alu_y), .cout(alu_cout)
    );

    // Write-bus source: external nibble or ALU result.
    assign c_bus = cw.src_alu ? alu_y : ext_in;

    tribus_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(d_sel), .wr_data(c_bus),
        .a_sel(a_sel), .b_sel(b_sel), .a_bus(a_bus), .b_bus(b_bus),
        .regs_flat(regs_q)
    );

endmodule

// File: rtl/tribus_datapath_chk.sv
// Checker: temporal properties of the datapath, observed at its ports only.
// Assumes: the control-word layout given in the package.
module tribus_datapath_chk #(
    parameter int DATA_W   = 4,
    parameter int NUM_REGS = 4,
    parameter int CTRL_W   = 13
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [CTRL_W-1:0]          ctrl,
    input logic [DATA_W-1:0]          ext_in,
    input logic [NUM_REGS*DATA_W-1:0] regs_q,
    input logic                       alu_cout
);

    function automatic logic [DATA_W-1:0] pick(
        input logic [NUM_REGS*DATA_W-1:0] v, input logic [1:0] idx);
        return v[idx*DATA_W +: DATA_W];
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> regs_q == '0);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> regs_q == $past(regs_q));

    // R3
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl[12]) |=> pick(regs_q, $past(ctrl[1:0])) == $past(ext_in));

    // R5
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl[12:6] == 7'b1001001) |=>
        pick(regs_q, $past(ctrl[1:0])) ==
        $past(DATA_W'(pick(regs_q, ctrl[5:4]) + pick(regs_q, ctrl[3:2]))));

    // R6
    sub_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl[12:6] == 7'b1010110) |=>
        pick(regs_q, $past(ctrl[1:0])) ==
        $past(DATA_W'(pick(regs_q, ctrl[5:4]) - pick(regs_q, ctrl[3:2]))));

    // R7
    and_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl[12:11] == 2'b11 && ctrl[9:6] == 4'b1011) |=>
        pick(regs_q, $past(ctrl[1:0])) ==
        $past(pick(regs_q, ctrl[5:4]) & pick(regs_q, ctrl[3:2])));

    // R9
    logic_cout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[11] |-> !alu_cout);

endmodule

bind tribus_datapath tribus_datapath_chk #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CTRL_W(CTRL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl(ctrl),
    .ext_in(ext_in), .regs_q(regs_q), .alu_cout(alu_cout)
);

// File: tb/sim_tribus_datapath.sv
// Bench: behavioural reference model compared after every applied cycle.
module sim_tribus_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] ctrl = '0;
    logic [3:0]  ext_in = '0;
    logic [15:0] regs_q;
    logic        alu_cout;

    int n_checks = 0;
    int n_fail   = 0;
    int mdl [4];

    always #2 clk = ~clk;   // 250 MHz

    tribus_datapath u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl(ctrl),
        .ext_in(ext_in), .regs_q(regs_q), .alu_cout(alu_cout)
    );

    // Behavioural model of the function table (R7, R8, R9).
    task automatic alu_ref(input bit m, input bit c, input bit [3:0] s,
                           input int a, input int b,
                           output int y, output bit co);
        int nb, nbb, t;
        nb  = (~b) & 15;
        nbb = (~a) & 15;
        if (m) begin
            case (s)
                4'b0000: t = nbb;
                4'b0001: t = ~(a | b);
                4'b0010: t = nbb & b;
                4'b0011: t = 0;
                4'b0100: t = ~(a & b);
                4'b0101: t = nb;
                4'b0110: t = a ^ b;
                4'b0111: t = a & nb;
                4'b1000: t = nbb | b;
                4'b1001: t = ~(a ^ b);
                4'b1010: t = b;
                4'b1011: t = a & b;
                4'b1100: t = 15;
                4'b1101: t = a | nb;
                4'b1110: t = a | b;
                default: t = a;
            endcase
            y  = t & 15;
            co = 1'b0;
        end else begin
            case (s)
                4'b0000: t = a;
                4'b0001: t = a | b;
                4'b0010: t = a | nb;
                4'b0011: t = 15;
                4'b0100: t = a + (a & nb);
                4'b0101: t = (a | b) + (a & nb);
                4'b0110: t = a + nb;
                4'b0111: t = (a & nb) + 15;
                4'b1000: t = a + (a & b);
                4'b1001: t = a + b;
                4'b1010: t = (a | nb) + (a & b);
                4'b1011: t = (a & b) + 15;
                4'b1100: t = a + a;
                4'b1101: t = (a | b) + a;
                4'b1110: t = (a | nb) + a;
                default: t = a + 15;
            endcase
            t  = t + int'(c);
            y  = t & 15;
            co = (t > 15);
        end
    endtask

    function automatic int model_flat();
        return (mdl[3] << 12) | (mdl[2] << 8) | (mdl[1] << 4) | mdl[0];
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Apply one control word just after a falling edge: check the carry in the
    // same cycle, then the registers one rising edge later.
    task automatic apply(input bit src, input bit m, input bit c,
                         input bit [3:0] s, input bit [1:0] a, input bit [1:0] b,
                         input bit [1:0] d, input bit we, input bit [3:0] din,
                         input string req);
        int y;
        bit co;
        ctrl   = {src, m, c, s, a, b, d};
        wr_en  = we;
        ext_in = din;
        alu_ref(m, c, s, mdl[a], mdl[b], y, co);
        #1;
        check({req, " cout"}, int'(alu_cout), int'(co));
        if (we) mdl[d] = src ? y : int'(din);
        @(negedge clk);
        check({req, " regs"}, int'(regs_q), model_flat());
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        foreach (mdl[i]) mdl[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset", int'(regs_q), 0);
        rst_n = 1'b1;

        // R3: loads from the external input, other fields don't-care.
        apply(0, 1, 1, 4'b1111, 3, 2, 0, 1, 4'd2, "R3");
        apply(0, 0, 0, 4'b0000, 1, 1, 1, 1, 4'd3, "R3");
        apply(0, 1, 0, 4'b1010, 0, 3, 2, 1, 4'd4, "R3");
        // R5 compound add: R3 = R0+R1, then R3 = R3+R2.
        apply(1, 0, 0, 4'b1001, 0, 1, 3, 1, 4'd0, "R5");
        apply(1, 0, 0, 4'b1001, 3, 2, 3, 1, 4'd0, "R5");
        check("R5 final R3", int'(regs_q[15:12]), 9);
        // R4: write strobe low leaves everything unchanged.
        apply(0, 0, 0, 4'b0000, 0, 0, 1, 0, 4'd15, "R4");
        apply(1, 0, 0, 4'b1001, 3, 3, 0, 0, 4'd0, "R4");
        // R6: R1=2, R0=3, R2 = R1 - R0 = 1111.
        apply(0, 0, 0, 4'b0000, 0, 0, 1, 1, 4'd2, "R6");
        apply(0, 0, 0, 4'b0000, 0, 0, 0, 1, 4'd3, "R6");
        apply(1, 0, 1, 4'b0110, 1, 0, 2, 1, 4'd0, "R6");
        check("R6 final R2", int'(regs_q[11:8]), 15);
        // R7: named logic functions with carry set (ignored).
        apply(1, 1, 1, 4'b1011, 2, 3, 0, 1, 4'd0, "R7 and");
        apply(1, 1, 1, 4'b1110, 1, 0, 3, 1, 4'd0, "R7 or");
        apply(1, 1, 0, 4'b0110, 2, 1, 1, 1, 4'd0, "R7 xor");
        apply(1, 1, 1, 4'b0000, 3, 0, 2, 1, 4'd0, "R7 nota");
        // R9: 15 + 1 produces a carry that is not stored.
        apply(0, 0, 0, 4'b0000, 0, 0, 0, 1, 4'd15, "R9");
        apply(0, 0, 0, 4'b0000, 0, 0, 1, 1, 4'd1, "R9");
        apply(1, 0, 0, 4'b1001, 0, 1, 2, 1, 4'd0, "R9 carry");
        // R10: same register on both buses and as destination.
        apply(1, 0, 0, 4'b1001, 1, 1, 1, 1, 4'd0, "R10");
        // R2, R8: sweep every field value.
        for (int k = 0; k < 400; k++) begin
            bit [12:0] w;
            w = 13'($urandom);
            apply(w[12], w[11], w[10], w[9:6], w[5:4], w[3:2], w[1:0],
                  ($urandom % 4) != 0, 4'($urandom), "R8 R2 sweep");
        end
        // R1: reset in mid-run.
        rst_n = 1'b0;
        wr_en = 1'b1;
        @(negedge clk);
        check("R1 midrun reset", int'(regs_q), 0);
        foreach (mdl[i]) mdl[i] = 0;
        rst_n = 1'b1;
        apply(0, 0, 0, 4'b0000, 0, 0, 3, 1, 4'd7, "R3 after reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule